// File: doc/BRIEF.md
# Anchor Byte Majority Detector

This block watches the received byte at the one position of each 48-byte test period where the far end sent an all-zero byte. A line segment that does not handle zero-substitution coding can turn that zero byte into some other value, and the received value can also vary from period to period. Bit errors and inconsistent handling of bipolar violations both cause this. A single non-zero sample is therefore not treated as proof of a problem. The block keeps a small table of distinct values seen at that position and counts how often each one arrives. It reports the value that occurred most often, together with its count.

A framing stage upstream pulses `anchor_vld` with the byte at the anchor position once per period, and holds `lock` high while it is synchronised. Dropping `lock`, or pulsing `start` to begin a new test, empties the table. `mismatch` is high whenever a winner exists and that winner is not the all-zero byte. How the zero byte is coded on the line is outside this block.

Top module: `anchor_majority_top`

## Requirements
- R1: After reset the table is empty: `best_valid`=0, `best_value`=0, `best_count`=0, `mismatch`=0.
- R2: A byte is taken only on a clock edge where `anchor_vld`=1, `lock`=1 and `start`=0. A strobe while `lock`=0 leaves every output unchanged.
- R3: A taken byte equal to a byte already in the table adds one to that entry's count. Outputs reflect the new count after that edge.
- R4: Counts are 16 bits wide and stop at 65535. Further matches leave an entry at 65535.
- R5: A taken byte that is not in the table, while fewer than 4 entries are held, becomes a new entry with count 1.
- R6: A new byte arriving with all 4 entries held replaces the entry with the lowest count. Among equal lowest counts, the one entered earliest is replaced. The new byte gets count 1 and counts as the most recently entered.
- R7: `best_value`/`best_count` give the entry with the highest count. On equal counts, the entry entered earliest wins. With no entries, both are 0.
- R8: `mismatch`=1 exactly when `best_valid`=1 and `best_value` is not 8'h00.
- R9: `lock`=0 or `start`=1 on an edge empties the table. This takes priority over a strobe on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Period alignment held; low clears all tallies |
| start | input | 1 | New-test pulse; clears all tallies |
| anchor_vld | input | 1 | Marks the byte at the anchor position |
| anchor_byte | input | 8 | Received byte at the anchor position |
| best_value | output | 8 | Most frequent anchor byte |
| best_count | output | 16 | Occurrences of `best_value` |
| best_valid | output | 1 | At least one entry is held |
| mismatch | output | 1 | Winner exists and is non-zero |

## Verification
Several properties are checked on every cycle by the assertions:
- a matching strobe steps its entry's count by one, or holds it at the ceiling;
- an edge with no taken byte changes nothing in the table;
- no held entry's count exceeds the reported best count;
- a clear always leaves the table empty;
- an all-zero winner never raises `mismatch`.

Some behaviour only the bench's scenarios and its cycle-by-cycle queue model can show:
- which entry is evicted when the table is full, including the oldest-first rule among equal lowest counts;
- the earliest-entered rule for tied winners;
- reaching saturation after 65535 samples.

// File: rtl/anchor_majority_pkg.sv
package anchor_majority_pkg;

  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned DEF_ENTRIES = 4;

  // Saturating increment; the caller widens and narrows to its own width.
  function automatic logic [63:0] sat_inc(input logic [63:0] cur, input logic [63:0] ceil);
    return (cur >= ceil) ? ceil : cur + 64'd1;
  endfunction

  // A verdict of "mismatch" is any held winner other than all zeros.
  function automatic logic is_mismatch(input logic have, input logic [63:0] value);
    return have && (value != 64'd0);
  endfunction

endpackage

// File: rtl/anchor_cand_table.sv
module anchor_cand_table #(
  parameter int unsigned DATA_W  = anchor_majority_pkg::DEF_DATA_W,
  parameter int unsigned CNT_W   = anchor_majority_pkg::DEF_CNT_W,
  parameter int unsigned ENTRIES = anchor_majority_pkg::DEF_ENTRIES
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            smp,
  input  logic [DATA_W-1:0]               smp_byte,
  output logic [ENTRIES-1:0][DATA_W-1:0]  ent_val,
  output logic [ENTRIES-1:0][CNT_W-1:0]   ent_cnt,
  output logic [ENTRIES-1:0]              ent_vld,
  output logic [ENTRIES-1:0]              hit_vec,
  output logic                            hit_any
);
  localparam int unsigned FILL_W = $clog2(ENTRIES + 1);
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Entries are kept packed and in order of entry: index 0 is the oldest.
  logic [ENTRIES-1:0][DATA_W-1:0] val_q, val_d;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q, cnt_d;
  logic [FILL_W-1:0]              fill_q, fill_d;
  logic [IDX_W-1:0]               victim;
  logic                           table_full;

  assign table_full = (fill_q == FILL_W'(ENTRIES));

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign ent_vld[g] = (FILL_W'(g) < fill_q);
      assign hit_vec[g] = ent_vld[g] && (val_q[g] == smp_byte);
    end
  endgenerate

  assign hit_any = |hit_vec;
  assign ent_val = val_q;
  assign ent_cnt = cnt_q;

  // Lowest count; strict compare keeps the oldest among equals.
  always_comb begin
    victim = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (cnt_q[i] < cnt_q[victim]) victim = IDX_W'(i);
    end
  end

  always_comb begin
    val_d  = val_q;
    cnt_d  = cnt_q;
    fill_d = fill_q;
    if (clr) begin
      val_d  = '0;
      cnt_d  = '0;
      fill_d = '0;
    end else if (smp) begin
      if (hit_any) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (hit_vec[i])
            cnt_d[i] = CNT_W'(anchor_majority_pkg::sat_inc(64'(cnt_q[i]), 64'(CNT_MAX)));
        end
      end else if (!table_full) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (FILL_W'(i) == fill_q) begin
            val_d[i] = smp_byte;
            cnt_d[i] = CNT_W'(1);
          end
        end
        fill_d = fill_q + FILL_W'(1);
      end else begin
        for (int i = 0; i < ENTRIES - 1; i++) begin
          if (IDX_W'(i) >= victim) begin
            val_d[i] = val_q[i+1];
            cnt_d[i] = cnt_q[i+1];
          end
        end
        val_d[ENTRIES-1] = smp_byte;
        cnt_d[ENTRIES-1] = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      cnt_q  <= '0;
      fill_q <= '0;
    end else begin
      val_q  <= val_d;
      cnt_q  <= cnt_d;
      fill_q <= fill_d;
    end
  end

  // R2: an edge with nothing taken and no clear leaves the table alone
  assert_table_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp && !clr) |=> ($stable(fill_q) && $stable(cnt_q) && $stable(val_q)));

  // R5: a miss with room grows the table by one entry
  assert_new_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && !clr && !hit_any && !table_full) |=> (fill_q == $past(fill_q) + FILL_W'(1)));

  generate
    for (g = 0; g < ENTRIES; g++) begin : g_chk
      // R3: a hit below the ceiling steps that entry by exactly one
      assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !clr && hit_vec[g] && cnt_q[g] != CNT_MAX) |=>
          (cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));
      // R4: a hit at the ceiling stays at the ceiling
      assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !clr && hit_vec[g] && cnt_q[g] == CNT_MAX) |=> (cnt_q[g] == CNT_MAX));
    end
  endgenerate

endmodule

// File: rtl/anchor_best_pick.sv
module anchor_best_pick #(
  parameter int unsigned DATA_W  = anchor_majority_pkg::DEF_DATA_W,
  parameter int unsigned CNT_W   = anchor_majority_pkg::DEF_CNT_W,
  parameter int unsigned ENTRIES = anchor_majority_pkg::DEF_ENTRIES
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0][DATA_W-1:0]  ent_val,
  input  logic [ENTRIES-1:0][CNT_W-1:0]   ent_cnt,
  input  logic [ENTRIES-1:0]              ent_vld,
  output logic [DATA_W-1:0]               best_val,
  output logic [CNT_W-1:0]                best_cnt,
  output logic                            best_vld
);
  // Walk from oldest to newest; strict greater keeps the earlier entry on ties.
  always_comb begin
    best_val = '0;
    best_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_vld[i] && ent_cnt[i] > best_cnt) begin
        best_val = ent_val[i];
        best_cnt = ent_cnt[i];
      end
    end
  end

  assign best_vld = |ent_vld;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_dom
      // R7: no held entry outranks the reported winner
      assert_best_dominates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld[g] |-> (ent_cnt[g] <= best_cnt));
    end
  endgenerate

endmodule

// File: rtl/anchor_majority_top.sv
module anchor_majority_top #(
  parameter int unsigned DATA_W  = anchor_majority_pkg::DEF_DATA_W,
  parameter int unsigned CNT_W   = anchor_majority_pkg::DEF_CNT_W,
  parameter int unsigned ENTRIES = anchor_majority_pkg::DEF_ENTRIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              start,
  input  logic              anchor_vld,
  input  logic [DATA_W-1:0] anchor_byte,
  output logic [DATA_W-1:0] best_value,
  output logic [CNT_W-1:0]  best_count,
  output logic              best_valid,
  output logic              mismatch
);
  logic                           tally_clr;
  logic                           tally_take;
  logic [ENTRIES-1:0][DATA_W-1:0] ent_val;
  logic [ENTRIES-1:0][CNT_W-1:0]  ent_cnt;
  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0]             hit_vec;
  logic                           hit_any;

  assign tally_clr  = !lock || start;
  assign tally_take = anchor_vld && lock && !start;

  anchor_cand_table #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ENTRIES(ENTRIES)) i_table (
    .clk(clk), .rst_n(rst_n), .clr(tally_clr), .smp(tally_take), .smp_byte(anchor_byte),
    .ent_val(ent_val), .ent_cnt(ent_cnt), .ent_vld(ent_vld),
    .hit_vec(hit_vec), .hit_any(hit_any));

  anchor_best_pick #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ENTRIES(ENTRIES)) i_pick (
    .clk(clk), .rst_n(rst_n), .ent_val(ent_val), .ent_cnt(ent_cnt), .ent_vld(ent_vld),
    .best_val(best_value), .best_cnt(best_count), .best_vld(best_valid));

  assign mismatch = anchor_majority_pkg::is_mismatch(best_valid, 64'(best_value));

  // R9: any clear edge leaves an empty table behind it
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tally_clr |=> (!best_valid && best_count == '0));

  // R8: an all-zero winner is never flagged
  assert_zero_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && best_value == '0) |-> !mismatch);

endmodule

// File: tb/test_anchor_majority_top.sv
module test_anchor_majority_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic       start = 1'b0;
  logic       anchor_vld = 1'b0;
  logic [7:0] anchor_byte = 8'h00;
  logic [7:0] best_value;
  logic [15:0] best_count;
  logic       best_valid;
  logic       mismatch;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  anchor_majority_top i_anchor_majority_top (
    .clk(clk), .rst_n(rst_n), .lock(lock), .start(start), .anchor_vld(anchor_vld),
    .anchor_byte(anchor_byte), .best_value(best_value), .best_count(best_count),
    .best_valid(best_valid), .mismatch(mismatch));

  // Behavioural model: values in order of entry, with their counts.
  int qv[$];
  int qc[$];
  int m_idx;
  int m_min;

  always @(posedge clk) begin
    if (!rst_n || !lock || start) begin
      qv.delete(); qc.delete();
    end else if (anchor_vld) begin
      m_idx = -1;
      foreach (qv[k]) if (qv[k] == int'(anchor_byte)) m_idx = k;
      if (m_idx >= 0) begin
        if (qc[m_idx] < 65535) qc[m_idx] = qc[m_idx] + 1;
      end else begin
        if (qv.size() == 4) begin
          m_min = 0;
          for (int k = 1; k < 4; k++) if (qc[k] < qc[m_min]) m_min = k;
          qv.delete(m_min); qc.delete(m_min);
        end
        qv.push_back(int'(anchor_byte)); qc.push_back(1);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    int ev, ec, eb;
    ev = 0; ec = 0; eb = (qv.size() > 0) ? 1 : 0;
    foreach (qv[k]) if (qc[k] > ec) begin ec = qc[k]; ev = qv[k]; end
    if (!done) begin
      chk("R7 best_value", int'(best_value), ev);
      chk("R7 best_count", int'(best_count), ec);
      chk("R1 best_valid", int'(best_valid), eb);
      chk("R8 mismatch", int'(mismatch), (eb == 1 && ev != 0) ? 1 : 0);
    end
  end

  task automatic send(input logic [7:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); anchor_vld = 1'b1; anchor_byte = v;
    end
    @(negedge clk); anchor_vld = 1'b0;
  endtask

  task automatic new_test();
    @(negedge clk); start = 1'b1; anchor_vld = 1'b1; anchor_byte = 8'h33;
    @(negedge clk); start = 1'b0; anchor_vld = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic [7:0] pool [7];
    pool = '{8'h00, 8'h1B, 8'h1D, 8'h55, 8'hAA, 8'hC3, 8'h7E};
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(best_valid), 0);
    chk("R1 reset count", int'(best_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mismatch", int'(mismatch), 0);

    // R2: strobes without lock are ignored
    send(8'h1B, 3);
    chk("R2 ignored valid", int'(best_valid), 0);
    chk("R2 ignored count", int'(best_count), 0);

    lock = 1'b1;
    new_test();
    chk("R9 start beats strobe", int'(best_valid), 0);
    send(8'h1B, 3);
    chk("R3 count", int'(best_count), 3);
    chk("R8 nonzero flag", int'(mismatch), 1);
    send(8'h00, 3);
    chk("R7 tie older wins", int'(best_value), 8'h1B);
    send(8'h00, 1);
    chk("R7 zero leads", int'(best_value), 0);
    chk("R8 zero no flag", int'(mismatch), 0);
    send(8'h1D, 1);
    chk("R5 newcomer not best", int'(best_count), 4);
    send(8'h55, 1);
    send(8'hAA, 1);          // evicts 1D (lowest, oldest of equals)
    send(8'h1D, 1);          // evicts 55
    send(8'hAA, 3);
    chk("R7 tie at 4 older wins", int'(best_value), 8'h00);
    send(8'h55, 1);          // evicts 1D
    send(8'hAA, 1);
    chk("R6 AA kept count", int'(best_count), 5);
    chk("R6 AA best", int'(best_value), 8'hAA);

    // R9: lock loss clears
    @(negedge clk); lock = 1'b0;
    @(negedge clk); lock = 1'b1;
    chk("R9 lock loss clears", int'(best_valid), 0);

    // R4: saturation
    new_test();
    send(8'h7E, 65540);
    chk("R4 saturate", int'(best_count), 65535);
    send(8'h7E, 2);
    chk("R4 held", int'(best_count), 65535);

    // Mixed traffic
    new_test();
    lf = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      anchor_vld = lf[0] | lf[5];
      anchor_byte = pool[int'(lf[11:8]) % 7];
      lock = (lf[15:9] != 7'h00);
      start = (lf[15:6] == 10'h3FF);
    end
    @(negedge clk); anchor_vld = 1'b0; start = 1'b0; lock = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule